// File: doc/BRIEF.md
# Predicated ALU with Flag Register

This block is the execute stage of a 32-bit load-store register machine. Each issued operation comes with an opcode, two operands, an optional shift on the second operand, a four-bit condition code and a set-flags bit. It can move, add, subtract, compare, add with signed saturation, or load the status flags directly. The condition is tested against the flags currently held. If the test fails, the operation has no effect: no result write and no flag change.

The unit holds a five-bit status register with the fields negative (N), zero (Z), carry (C), overflow (V) and sticky saturation (Q). Flags change only on a compare, on an arithmetic operation that has its set-flags bit asserted, on a saturating add that clamps (this sets Q), or on a direct flag load. The result and its write-enable are registered with one cycle of latency. The flags update on the same clock edge. Fetch, decode, the register file and memory access sit outside the block.

Top module: `pred_alu`

## Requirements
- R1: While reset is asserted and on the first cycle after it, result_o is 0, res_we_o is 0 and flags_o is 0.
- R2: An issued operation whose condition passes shows its result and write-enable on the first clock edge after issue. Flags change on that same edge.
- R3: The second operand is shifted before use. shift_type_i=0 gives a logical left shift by shift_amt_i. shift_type_i=1 gives an arithmetic right shift with sign extension. Move (op 0) writes the shifted operand.
- R4: Add (op 1) writes A+B and subtract (op 2) writes A-B. With set_flags_i=0 all five flags keep their values.
- R5: The flag order is flags_o = {N,Z,C,V,Q}, from bit 4 down to bit 0. Add with set-flags sets C to the carry out and sets V when the operands have the same sign and the result sign differs. Subtract and compare set C when no borrow occurs and set V when the operands have different signs and the result sign differs from A. N is the result MSB. Z is set when the result is zero.
- R6: Compare (op 3) loads N, Z, C and V from A-B and never asserts res_we_o.
- R7: The condition codes are EQ=0 (Z), NE=1 (!Z), CS=2 (C), CC=3 (!C), MI=4 (N), PL=5 (!N), VS=6 (V), VC=7 (!V), HI=8 (C&!Z), LS=9 (!C|Z), GE=10 (N==V), LT=11 (N!=V), GT=12 (!Z&N==V) and LE=13 (Z|N!=V). When the condition is false, res_we_o is 0 and the flags do not change.
- R8: Code 14 always passes. Code 15 never passes.
- R9: Saturating add (op 4) clamps to 0x7FFFFFFF or 0x80000000 on signed overflow and then sets Q. Q is sticky: nothing clears it except a direct flag load.
- R10: Flag load (op 5) copies opb_i[4:0] (unshifted) into flags_o in the R5 order. It asserts no write-enable.
- R11: A subtract with set-flags that reaches zero sets Z, so a countdown needs no separate compare.
- R12: With in_valid=0, res_we_o is 0 on the next cycle and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is issued this cycle |
| op_i | input | 3 | Opcode: 0 move, 1 add, 2 subtract, 3 compare, 4 saturating add, 5 flag load |
| set_flags_i | input | 1 | Arithmetic operation updates flags |
| cond_i | input | 4 | Condition code (R7) |
| opa_i | input | DATA_W | Operand A |
| opb_i | input | DATA_W | Operand B, before the shift |
| shift_type_i | input | 1 | 0 logical left, 1 arithmetic right |
| shift_amt_i | input | SHAMT_W | Shift distance |
| result_o | output | DATA_W | Registered result |
| res_we_o | output | 1 | Registered result write-enable |
| flags_o | output | 5 | {N,Z,C,V,Q} |

## Verification
The hardest states to reach are those in which one condition code depends on a flag combination that only an earlier operation could have produced. Examples are LT passing with N clear and V set, and Q held across a later flag-setting add. The stimulus table is ordered so that each row leaves the flags that the next row's condition needs. For instance, a compare of 0x80000000 with 1 leaves V set and N clear, and the following row depends on that. The bench also makes the flags evolve over a short countdown of subtracts and checks that Z rises only on the last step.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

    typedef enum logic [2:0] {
        OP_MOV    = 3'd0,
        OP_ADD    = 3'd1,
        OP_SUB    = 3'd2,
        OP_CMP    = 3'd3,
        OP_QADD   = 3'd4,
        OP_FLAGLD = 3'd5
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef enum logic {
        SH_LSL = 1'b0,
        SH_ASR = 1'b1
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
        logic q;
    } flags_t;

endpackage

// File: rtl/pa_shifter.sv
module pa_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [DATA_W-1:0]  val_i,
    input  logic               kind_i,
    input  logic [SHAMT_W-1:0] dist_i,
    output logic [DATA_W-1:0]  val_o
);
    import pred_alu_pkg::*;

    always_comb begin
        unique case (shift_e'(kind_i))
            SH_LSL:  val_o = val_i << dist_i;
            SH_ASR:  val_o = DATA_W'($signed(val_i) >>> dist_i);
            default: val_o = val_i;
        endcase
    end
endmodule

// File: rtl/pa_cond_eval.sv
module pa_cond_eval (
    input  logic [3:0]           cond_i,
    input  pred_alu_pkg::flags_t fl_i,
    output logic                 pass_o
);
    import pred_alu_pkg::*;

    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ:   pass_o = fl_i.z;
            CC_NE:   pass_o = !fl_i.z;
            CC_CS:   pass_o = fl_i.c;
            CC_CC:   pass_o = !fl_i.c;
            CC_MI:   pass_o = fl_i.n;
            CC_PL:   pass_o = !fl_i.n;
            CC_VS:   pass_o = fl_i.v;
            CC_VC:   pass_o = !fl_i.v;
            CC_HI:   pass_o = fl_i.c && !fl_i.z;
            CC_LS:   pass_o = !fl_i.c || fl_i.z;
            CC_GE:   pass_o = (fl_i.n == fl_i.v);
            CC_LT:   pass_o = (fl_i.n != fl_i.v);
            CC_GT:   pass_o = !fl_i.z && (fl_i.n == fl_i.v);
            CC_LE:   pass_o = fl_i.z || (fl_i.n != fl_i.v);
            CC_AL:   pass_o = 1'b1;
            CC_NV:   pass_o = 1'b0;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pa_arith.sv
module pa_arith #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]           op_i,
    input  logic                 sf_i,
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W-1:0]    b_i,
    input  logic [DATA_W-1:0]    b_raw_i,
    input  pred_alu_pkg::flags_t fl_i,
    output logic [DATA_W-1:0]    res_o,
    output logic                 we_o,
    output pred_alu_pkg::flags_t fl_o
);
    import pred_alu_pkg::*;

    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic              add_ovf;
    logic              sub_ovf;
    logic [DATA_W-1:0] sat_val;

    assign sum_w   = {1'b0, a_i} + {1'b0, b_i};
    assign dif_w   = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
    assign add_ovf = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
    assign sub_ovf = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);
    assign sat_val = add_ovf ? (a_i[MSB] ? SMIN : SMAX) : sum_w[DATA_W-1:0];

    always_comb begin
        res_o = '0;
        we_o  = 1'b0;
        fl_o  = fl_i;
        unique case (alu_op_e'(op_i))
            OP_MOV: begin
                res_o = b_i;
                we_o  = 1'b1;
                if (sf_i) begin
                    fl_o.n = b_i[MSB];
                    fl_o.z = (b_i == '0);
                end
            end
            OP_ADD: begin
                res_o = sum_w[DATA_W-1:0];
                we_o  = 1'b1;
                if (sf_i) begin
                    fl_o.n = sum_w[MSB];
                    fl_o.z = (sum_w[DATA_W-1:0] == '0);
                    fl_o.c = sum_w[DATA_W];
                    fl_o.v = add_ovf;
                end
            end
            OP_SUB, OP_CMP: begin
                res_o = dif_w[DATA_W-1:0];
                we_o  = (op_i == OP_SUB);
                if (sf_i || op_i == OP_CMP) begin
                    fl_o.n = dif_w[MSB];
                    fl_o.z = (dif_w[DATA_W-1:0] == '0);
                    fl_o.c = dif_w[DATA_W];
                    fl_o.v = sub_ovf;
                end
            end
            OP_QADD: begin
                res_o = sat_val;
                we_o  = 1'b1;
                if (add_ovf) fl_o.q = 1'b1;
                if (sf_i) begin
                    fl_o.n = sat_val[MSB];
                    fl_o.z = (sat_val == '0);
                end
            end
            OP_FLAGLD: begin
                fl_o = flags_t'(b_raw_i[4:0]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pred_alu.sv
module pred_alu #(
    parameter int DATA_W = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op_i,
    input  logic               set_flags_i,
    input  logic [3:0]         cond_i,
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    input  logic               shift_type_i,
    input  logic [SHAMT_W-1:0] shift_amt_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               res_we_o,
    output logic [4:0]         flags_o
);
    import pred_alu_pkg::*;

    flags_t            fl_q;
    flags_t            fl_nx;
    logic [DATA_W-1:0] b_shifted;
    logic [DATA_W-1:0] ar_res;
    logic              ar_we;
    logic              cond_ok;
    logic              fire;

    pa_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .val_i  (opb_i),
        .kind_i (shift_type_i),
        .dist_i (shift_amt_i),
        .val_o  (b_shifted)
    );

    pa_cond_eval u_cond (
        .cond_i (cond_i),
        .fl_i   (fl_q),
        .pass_o (cond_ok)
    );

    pa_arith #(.DATA_W(DATA_W)) u_arith (
        .op_i    (op_i),
        .sf_i    (set_flags_i),
        .a_i     (opa_i),
        .b_i     (b_shifted),
        .b_raw_i (opb_i),
        .fl_i    (fl_q),
        .res_o   (ar_res),
        .we_o    (ar_we),
        .fl_o    (fl_nx)
    );

    assign fire = in_valid && cond_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else if (fire) begin
            fl_q <= fl_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            res_we_o <= 1'b0;
        end else begin
            res_we_o <= fire && ar_we;
            if (fire && ar_we) result_o <= ar_res;
        end
    end

    assign flags_o = fl_q;
endmodule

// File: rtl/pred_alu_chk.sv
module pred_alu_chk #(
    parameter int DATA_W = 32,
    parameter int SHAMT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [2:0]         op_i,
    input logic               set_flags_i,
    input logic [3:0]         cond_i,
    input logic [DATA_W-1:0]  result_o,
    input logic               res_we_o,
    input logic [4:0]         flags_o
);
    import pred_alu_pkg::*;

    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_i == OP_CMP |=> !res_we_o);

    a_r8_never_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cond_i == CC_NV |=> !res_we_o && $stable(flags_o));

    a_r8_always_moves: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cond_i == CC_AL && op_i == OP_MOV |=> res_we_o);

    a_r4_add_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_i == OP_ADD && !set_flags_i |=> $stable(flags_o));

    a_r9_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[0]) |-> $past(in_valid && op_i == OP_FLAGLD));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_we_o && $stable(flags_o));

    a_r2_we_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_o |-> $past(in_valid));
endmodule

bind pred_alu pred_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_i        (op_i),
    .set_flags_i (set_flags_i),
    .cond_i      (cond_i),
    .result_o    (result_o),
    .res_we_o    (res_we_o),
    .flags_o     (flags_o)
);

// File: tb/pred_alu_test.sv
module pred_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_i = '0;
    logic        set_flags_i = 1'b0;
    logic [3:0]  cond_i = 4'd14;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        shift_type_i = 1'b0;
    logic [4:0]  shift_amt_i = '0;
    logic [31:0] result_o;
    logic        res_we_o;
    logic [4:0]  flags_o;

    int checks = 0;
    int errors = 0;

    always #4ns clk = ~clk;

    pred_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .set_flags_i(set_flags_i), .cond_i(cond_i), .opa_i(opa_i),
        .opb_i(opb_i), .shift_type_i(shift_type_i), .shift_amt_i(shift_amt_i),
        .result_o(result_o), .res_we_o(res_we_o), .flags_o(flags_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        sf;
        logic [3:0]  cond;
        logic [31:0] a;
        logic [31:0] b;
        logic        sht;
        logic [4:0]  sam;
        logic        ewe;
        logic [31:0] eres;
        logic [4:0]  efl;
        logic [7:0]  req;
    } vec_t;

    // flags {N,Z,C,V,Q}; rows depend on the flags left by earlier rows
    localparam vec_t TBL [23] = '{
        '{3'd0,1'b0,4'd14,32'h0,32'h5,1'b0,5'd3,1'b1,32'd40,5'b00000,8'd3},                  // R3 LSL
        '{3'd0,1'b0,4'd14,32'h0,32'h80000000,1'b1,5'd4,1'b1,32'hF8000000,5'b00000,8'd3},    // R3 ASR sign
        '{3'd1,1'b0,4'd14,32'hFFFFFFFF,32'h1,1'b0,5'd0,1'b1,32'h0,5'b00000,8'd4},           // R4 no flags
        '{3'd1,1'b1,4'd14,32'hFFFFFFFF,32'h1,1'b0,5'd0,1'b1,32'h0,5'b01100,8'd5},           // R5 carry
        '{3'd1,1'b1,4'd14,32'h7FFFFFFF,32'h1,1'b0,5'd0,1'b1,32'h80000000,5'b10010,8'd5},    // R5 overflow
        '{3'd3,1'b0,4'd14,32'h3,32'h5,1'b0,5'd0,1'b0,32'h0,5'b10000,8'd6},                  // R6 borrow
        '{3'd2,1'b0,4'd3,32'd10,32'd2,1'b0,5'd1,1'b1,32'd6,5'b10000,8'd7},                  // R7 CC true
        '{3'd2,1'b0,4'd0,32'd10,32'd4,1'b0,5'd0,1'b0,32'h0,5'b10000,8'd7},                  // R7 EQ false
        '{3'd1,1'b0,4'd11,32'd1,32'd8,1'b1,5'd2,1'b1,32'd3,5'b10000,8'd7},                  // R7 LT true
        '{3'd3,1'b0,4'd14,32'd5,32'd5,1'b0,5'd0,1'b0,32'h0,5'b01100,8'd6},                  // R6 equal
        '{3'd0,1'b0,4'd1,32'h0,32'd7,1'b0,5'd0,1'b0,32'h0,5'b01100,8'd7},                   // R7 NE false
        '{3'd0,1'b0,4'd0,32'h0,32'd7,1'b0,5'd0,1'b1,32'd7,5'b01100,8'd7},                   // R7 EQ true
        '{3'd3,1'b0,4'd14,32'h80000000,32'h1,1'b0,5'd0,1'b0,32'h0,5'b00110,8'd5},           // R5 sub V
        '{3'd1,1'b0,4'd11,32'h0,32'h1,1'b0,5'd0,1'b1,32'd1,5'b00110,8'd7},                  // R7 LT N0 V1
        '{3'd0,1'b0,4'd15,32'h0,32'd9,1'b0,5'd0,1'b0,32'h0,5'b00110,8'd8},                  // R8 never
        '{3'd1,1'b1,4'd10,32'd1,32'd1,1'b0,5'd0,1'b0,32'h0,5'b00110,8'd7},                  // R7 GE false
        '{3'd4,1'b0,4'd14,32'h7FFFFFF0,32'h20,1'b0,5'd0,1'b1,32'h7FFFFFFF,5'b00111,8'd9},   // R9 clamp hi
        '{3'd4,1'b0,4'd14,32'd5,32'd6,1'b0,5'd0,1'b1,32'd11,5'b00111,8'd9},                 // R9 sticky
        '{3'd4,1'b0,4'd14,32'h80000000,32'hFFFFFFFF,1'b0,5'd0,1'b1,32'h80000000,5'b00111,8'd9}, // R9 clamp lo
        '{3'd1,1'b1,4'd14,32'd1,32'd1,1'b0,5'd0,1'b1,32'd2,5'b00001,8'd9},                  // R9 Q kept
        '{3'd5,1'b0,4'd14,32'h0,32'h14,1'b0,5'd0,1'b0,32'h0,5'b10100,8'd10},                // R10 load
        '{3'd5,1'b0,4'd3,32'h0,32'h0,1'b0,5'd0,1'b0,32'h0,5'b10100,8'd10},                  // R10 cond false
        '{3'd5,1'b0,4'd14,32'h0,32'h0,1'b0,5'd0,1'b0,32'h0,5'b00000,8'd10}                  // R10 clears Q
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic sf, input logic [3:0] cc,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic st, input logic [4:0] sa);
        in_valid = 1'b1; op_i = op; set_flags_i = sf; cond_i = cc;
        opa_i = a; opb_i = b; shift_type_i = st; shift_amt_i = sa;
        @(negedge clk);
    endtask

    initial begin
        #(8ns * 100000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(result_o == 0 && !res_we_o && flags_o == 0, "R1 in reset",
            {result_o[26:0], res_we_o, flags_o[3:0]}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result_o == 0 && !res_we_o && flags_o == 0, "R1 after reset",
            {result_o[26:0], res_we_o, flags_o[3:0]}, 32'h0);

        for (int i = 0; i < 23; i++) begin
            issue(TBL[i].op, TBL[i].sf, TBL[i].cond, TBL[i].a, TBL[i].b,
                  TBL[i].sht, TBL[i].sam);
            chk(res_we_o == TBL[i].ewe, $sformatf("R%0d/R2 row %0d we", TBL[i].req, i),
                32'(res_we_o), 32'(TBL[i].ewe));
            if (TBL[i].ewe)
                chk(result_o == TBL[i].eres, $sformatf("R%0d row %0d result", TBL[i].req, i),
                    result_o, TBL[i].eres);
            chk(flags_o == TBL[i].efl, $sformatf("R%0d row %0d flags", TBL[i].req, i),
                32'(flags_o), 32'(TBL[i].efl));
        end

        // R12: idle cycle with a flag-setting add on the bus
        in_valid = 1'b0; op_i = 3'd1; set_flags_i = 1'b1; cond_i = 4'd14;
        opa_i = 32'hFFFFFFFF; opb_i = 32'h1; shift_amt_i = '0;
        @(negedge clk);
        chk(!res_we_o && flags_o == 5'b00000, "R12 idle",
            {res_we_o, 26'd0, flags_o}, 32'h0);

        // R11: countdown by subtract-with-flags, Z only on the last step
        for (int k = 3; k > 0; k--) begin
            issue(3'd2, 1'b1, 4'd14, 32'(k), 32'd1, 1'b0, 5'd0);
            chk(result_o == 32'(k - 1) && res_we_o, "R11 count value",
                result_o, 32'(k - 1));
            chk(flags_o == ((k == 1) ? 5'b01100 : 5'b00100), "R11 count flags",
                32'(flags_o), (k == 1) ? 32'h0C : 32'h04);
        end
        in_valid = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule